// File: doc/BRIEF.md
# Activity-Driven Bus Clock Slowdown Controller

This block generates a one-cycle clock-enable pulse train for a system bus domain that runs from a faster root clock. A base divider register sets the normal bus rate. When automatic slowdown is enabled and no qualifying activity has been seen for a while, the pulse period grows by a selectable power-of-two factor. The bus returns to the normal rate as soon as an enabled activity source fires, or as soon as the bus becomes congested.

There are eight activity sources. Each one forces the normal rate only while its own enable bit is set. The sources are CPU instruction fetch, CPU data access, generic master traffic, two DMA engines, a crypto engine, a pixel engine and a memory-port request. A congestion rule counts how many bus masters are active at once. A wakeup interrupt can return the base divider to one on its own, so that a core waking from a very slow bus clock speeds up without waiting for software.

Top module: `bus_clk_slowdown`

## Requirements
- R1: During and after reset, the base divider reads 1, the slow flag is 0 and `clk_en_o` pulses on every root cycle.
- R2: With automatic slowdown off, `clk_en_o` pulses once every D root cycles, where D is the base divider value. A divider value of 0 acts as 1.
- R3: In slow mode the pulse period is D times a ratio. The ratio is chosen by the 3-bit `slow_code_i`: codes 0, 1, 2, 3, 4 and 5 give ratios 1, 2, 4, 8, 16 and 32, and codes 6 and 7 give a ratio of 1.
- R4: While `auto_slow_en_i` is 0, `slow_o` stays 0 after the next pulse boundary, whatever the activity inputs are.
- R5: An activity bit in `act_i` whose matching bit in `src_en_i` is 0 has no effect on the rate.
- R6: An enabled activity holds the normal rate. Slow mode starts only after HOLD_PULSES (default 16) enable pulses in a row with no fast-mode event, and the switch happens at the next pulse boundary.
- R7: With `jam_en_i` set, three or more active bits in `master_act_i` count as a fast-mode event. Fewer than three active masters, or `jam_en_i` clear, do not.
- R8: With `auto_clr_en_i` set, `wake_irq_i` loads 1 into the base divider on the next clock. The enable stays armed, so later wakeups clear the divider again. With `auto_clr_en_i` clear, a wakeup leaves the divider unchanged.
- R9: A software write (`div_wr_i`) in the same cycle as an armed wakeup wins, and the written value is stored.
- R10: A change of divider or rate takes effect only at a pulse boundary. The gap between two pulses always equals the period latched at the first of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Root clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_wr_i | input | 1 | Software write strobe for the base divider |
| div_data_i | input | DIV_W | Value written to the base divider |
| auto_slow_en_i | input | 1 | Global automatic slowdown enable |
| slow_code_i | input | 3 | Slow ratio select code |
| src_en_i | input | NUM_SRC | Per-source fast-event enables |
| act_i | input | NUM_SRC | Per-source activity (0 instr, 1 data, 2 any master, 3 DMA A, 4 DMA B, 5 crypto, 6 pixel, 7 memory port) |
| jam_en_i | input | 1 | Congestion rule enable |
| master_act_i | input | NUM_MST | One bit per active bus master |
| auto_clr_en_i | input | 1 | Arms the wakeup divider clear |
| wake_irq_i | input | 1 | Wakeup interrupt event |
| clk_en_o | output | 1 | One-cycle bus clock-enable pulse |
| slow_o | output | 1 | High while the current period is a slow one |
| base_div_o | output | DIV_W | Current base divider register value |

## Verification
The bench runs a behavioural model next to the design and targets the moments where rates change. It covers the exact pulse at which the hold count runs out: a design that counts root cycles instead of pulses, or that is off by one, switches to slow one period too early or too late. It checks that a rate change in the middle of a period waits for the boundary, since a design that cuts the period short emits a pulse early. It covers the congestion rule at exactly two and exactly three active masters, and a comparison written as "more than three" stays slow at three. It covers divider value 0 and the reserved ratio codes, and it drives a write in the same cycle as an armed wakeup, where the wrong priority leaves the divider at 1.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
   localparam int CODE_W    = 3;
   localparam int MAX_SHIFT = 5;

   // Slow ratio exponent for a code; reserved codes fall back to ratio 1.
   function automatic logic [CODE_W-1:0] ratio_shift(input logic [CODE_W-1:0] code);
      return (int'(code) <= MAX_SHIFT) ? code : '0;
   endfunction
endpackage

// File: rtl/bcs_activity.sv
module bcs_activity #(
   parameter int NUM_SRC    = 8,
   parameter int NUM_MST    = 8,
   parameter int JAM_THRESH = 3,
   parameter bit HAS_JAM    = 1'b1
) (
   input  logic [NUM_SRC-1:0] src_en_i,
   input  logic [NUM_SRC-1:0] act_i,
   input  logic               jam_en_i,
   input  logic [NUM_MST-1:0] master_act_i,
   output logic               fast_evt_o
);
   localparam int CNT_W = $clog2(NUM_MST + 1);

   logic src_hit;
   logic jam_hit;

   assign src_hit = |(src_en_i & act_i);

   generate
      if (HAS_JAM) begin : g_jam
         logic [CNT_W-1:0] n_act;
         always_comb begin
            n_act = '0;
            for (int i = 0; i < NUM_MST; i++) n_act = n_act + CNT_W'(master_act_i[i]);
         end
         assign jam_hit = jam_en_i && (int'(n_act) >= JAM_THRESH);
      end else begin : g_nojam
         logic unused_jam;
         assign unused_jam = jam_en_i ^ (^master_act_i);
         assign jam_hit    = 1'b0;
      end
   endgenerate

   assign fast_evt_o = src_hit | jam_hit;
endmodule

// File: rtl/bcs_rate_sel.sv
module bcs_rate_sel #(
   parameter int HOLD_PULSES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_slow_en_i,
   input  logic fast_evt_i,
   input  logic pulse_i,
   output logic want_slow_o
);
   localparam int HOLD_W = $clog2(HOLD_PULSES + 1);
   localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(HOLD_PULSES);

   logic [HOLD_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            hold_q <= HOLD_INIT;
      else if (!auto_slow_en_i || fast_evt_i) hold_q <= HOLD_INIT;
      else if (pulse_i && hold_q != '0)       hold_q <= hold_q - 1'b1;
   end

   assign want_slow_o = auto_slow_en_i && !fast_evt_i && (hold_q == '0);

   assert_hold_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fast_evt_i |=> hold_q == HOLD_INIT);
   assert_hold_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pulse_i && auto_slow_en_i && !fast_evt_i) |=> $stable(hold_q));
endmodule

// File: rtl/bcs_div_reg.sv
module bcs_div_reg #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [DIV_W-1:0] data_i,
   input  logic             auto_clr_en_i,
   input  logic             wake_i,
   output logic [DIV_W-1:0] div_o
);
   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      div_o <= ONE;
      else if (wr_i)                   div_o <= data_i;
      else if (auto_clr_en_i && wake_i) div_o <= ONE;
   end

   assert_wake_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_clr_en_i && wake_i && !wr_i) |=> div_o == ONE);
   assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> div_o == $past(data_i));
   assert_wake_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_clr_en_i && !wr_i) |=> $stable(div_o));
endmodule

// File: rtl/bcs_divider.sv
module bcs_divider
   import bcs_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div_i,
   input  logic [CODE_W-1:0] slow_code_i,
   input  logic              want_slow_i,
   output logic              pulse_o,
   output logic              slow_o
);
   localparam int PER_W = DIV_W + MAX_SHIFT + 1;

   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] per_q;
   logic [PER_W-1:0] eff;
   logic [PER_W-1:0] per_next;

   assign eff      = (div_i == '0) ? PER_W'(1) : PER_W'(div_i);
   assign per_next = want_slow_i ? (eff << ratio_shift(slow_code_i)) : eff;
   assign pulse_o  = (cnt_q == per_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         per_q  <= PER_W'(1);
         slow_o <= 1'b0;
      end else if (pulse_o) begin
         cnt_q  <= '0;
         per_q  <= per_next;
         slow_o <= want_slow_i;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assert_period_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !pulse_o |=> ($stable(per_q) && $stable(slow_o)));
   assert_period_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      per_q != '0);
   assert_count_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < per_q);
endmodule

// File: rtl/bus_clk_slowdown.sv
module bus_clk_slowdown
   import bcs_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int NUM_SRC     = 8,
   parameter int NUM_MST     = 8,
   parameter int JAM_THRESH  = 3,
   parameter int HOLD_PULSES = 16,
   parameter bit HAS_JAM     = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               div_wr_i,
   input  logic [DIV_W-1:0]   div_data_i,
   input  logic               auto_slow_en_i,
   input  logic [CODE_W-1:0]  slow_code_i,
   input  logic [NUM_SRC-1:0] src_en_i,
   input  logic [NUM_SRC-1:0] act_i,
   input  logic               jam_en_i,
   input  logic [NUM_MST-1:0] master_act_i,
   input  logic               auto_clr_en_i,
   input  logic               wake_irq_i,
   output logic               clk_en_o,
   output logic               slow_o,
   output logic [DIV_W-1:0]   base_div_o
);
   generate
      if (DIV_W < 1 || DIV_W > 24) begin : g_bad_div
         $error("DIV_W out of range");
      end
      if (NUM_SRC < 1) begin : g_bad_src
         $error("NUM_SRC must be positive");
      end
      if (HAS_JAM && (JAM_THRESH < 1 || JAM_THRESH > NUM_MST)) begin : g_bad_jam
         $error("JAM_THRESH must lie in 1..NUM_MST");
      end
      if (HOLD_PULSES < 1) begin : g_bad_hold
         $error("HOLD_PULSES must be positive");
      end
   endgenerate

   logic fast_evt;
   logic want_slow;

   bcs_activity #(
      .NUM_SRC(NUM_SRC), .NUM_MST(NUM_MST), .JAM_THRESH(JAM_THRESH), .HAS_JAM(HAS_JAM)
   ) u_activity (
      .src_en_i(src_en_i), .act_i(act_i), .jam_en_i(jam_en_i),
      .master_act_i(master_act_i), .fast_evt_o(fast_evt)
   );

   bcs_rate_sel #(.HOLD_PULSES(HOLD_PULSES)) u_rate (
      .clk(clk), .rst_n(rst_n), .auto_slow_en_i(auto_slow_en_i),
      .fast_evt_i(fast_evt), .pulse_i(clk_en_o), .want_slow_o(want_slow)
   );

   bcs_div_reg #(.DIV_W(DIV_W)) u_divreg (
      .clk(clk), .rst_n(rst_n), .wr_i(div_wr_i), .data_i(div_data_i),
      .auto_clr_en_i(auto_clr_en_i), .wake_i(wake_irq_i), .div_o(base_div_o)
   );

   bcs_divider #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .div_i(base_div_o), .slow_code_i(slow_code_i),
      .want_slow_i(want_slow), .pulse_o(clk_en_o), .slow_o(slow_o)
   );

   assert_no_slow_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_slow_en_i && clk_en_o) |=> !slow_o);
   assert_fast_on_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_evt && clk_en_o) |=> !slow_o);
endmodule

// File: tb/bus_clk_slowdown_bench.sv
`timescale 1ns/1ps
module bus_clk_slowdown_bench;
   localparam int HOLD = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       div_wr_i = 1'b0;
   logic [7:0] div_data_i = '0;
   logic       auto_slow_en_i = 1'b0;
   logic [2:0] slow_code_i = '0;
   logic [7:0] src_en_i = '0;
   logic [7:0] act_i = '0;
   logic       jam_en_i = 1'b0;
   logic [7:0] master_act_i = '0;
   logic       auto_clr_en_i = 1'b0;
   logic       wake_irq_i = 1'b0;
   logic       clk_en_o;
   logic       slow_o;
   logic [7:0] base_div_o;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   string tag = "R1";

   int m_div = 1, m_hold = HOLD, m_cnt = 0, m_per = 1;
   bit m_slow = 1'b0;

   always #2 clk = ~clk;

   bus_clk_slowdown u_bus_clk_slowdown (
      .clk(clk), .rst_n(rst_n), .div_wr_i(div_wr_i), .div_data_i(div_data_i),
      .auto_slow_en_i(auto_slow_en_i), .slow_code_i(slow_code_i),
      .src_en_i(src_en_i), .act_i(act_i), .jam_en_i(jam_en_i),
      .master_act_i(master_act_i), .auto_clr_en_i(auto_clr_en_i),
      .wake_irq_i(wake_irq_i), .clk_en_o(clk_en_o), .slow_o(slow_o),
      .base_div_o(base_div_o)
   );

   task automatic chk(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
      end
   endtask

   // Behavioural reference model, advanced on every rising edge.
   always @(posedge clk) begin
      if (!rst_n) begin
         m_div = 1; m_hold = HOLD; m_cnt = 0; m_per = 1; m_slow = 1'b0;
      end else begin
         bit pulse, fast, want;
         int eff, nmst, ratio;
         pulse = (m_cnt == m_per - 1);
         nmst = $countones(master_act_i);
         fast = ((src_en_i & act_i) != 0) || (jam_en_i && nmst >= 3);
         eff = (m_div == 0) ? 1 : m_div;
         ratio = (slow_code_i <= 5) ? (1 << slow_code_i) : 1;
         want = auto_slow_en_i && !fast && (m_hold == 0);
         if (!auto_slow_en_i || fast) m_hold = HOLD;
         else if (pulse && m_hold > 0) m_hold = m_hold - 1;
         if (pulse) begin
            m_cnt = 0; m_slow = want; m_per = want ? eff * ratio : eff;
         end else m_cnt = m_cnt + 1;
         if (div_wr_i) m_div = div_data_i;
         else if (auto_clr_en_i && wake_irq_i) m_div = 1;
      end
   end

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         chk(tag, clk_en_o, (m_cnt == m_per - 1) ? 1 : 0, "clk_en_o");
         chk(tag, slow_o, m_slow, "slow_o");
         chk(tag, base_div_o, m_div, "base_div_o");
      end
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      run(3);
      // R1: reset values while reset is held
      chk("R1", base_div_o, 1, "reset divider");
      chk("R1", slow_o, 0, "reset slow");
      chk("R1", clk_en_o, 1, "reset pulse");
      rst_n = 1'b1;
      run(5);

      // R2: fixed divide, then divide value 0
      tag = "R2";
      div_wr_i = 1; div_data_i = 3; run(1); div_wr_i = 0;
      run(30);
      div_wr_i = 1; div_data_i = 0; run(1); div_wr_i = 0;
      run(10);
      chk("R2", base_div_o, 0, "zero divider stored");

      // R3/R6: auto slow with code 2, hold then slow
      tag = "R6";
      div_wr_i = 1; div_data_i = 3; run(1); div_wr_i = 0;
      slow_code_i = 3'd2; auto_slow_en_i = 1;
      run(120);
      tag = "R3";
      run(100);
      chk("R3", slow_o, 1, "slow after hold");

      // R5: activity on masked sources has no effect
      tag = "R5";
      act_i = 8'hFF; src_en_i = 8'h00;
      run(100);
      chk("R5", slow_o, 1, "masked activity ignored");

      // R6/R10: enabled source forces fast mid slow period, then release
      tag = "R10";
      src_en_i = 8'h08; act_i = 8'h08;
      run(60);
      chk("R6", slow_o, 0, "fast while active");
      tag = "R6";
      act_i = 8'h00;
      run(160);

      // R3: largest and reserved ratio codes
      tag = "R3";
      slow_code_i = 3'd5; run(400);
      slow_code_i = 3'd6; run(60);
      slow_code_i = 3'd7; run(60);
      slow_code_i = 3'd1; run(60);

      // R7: congestion rule
      tag = "R7";
      jam_en_i = 1; master_act_i = 8'b0000_0011; run(80);
      chk("R7", slow_o, 1, "two masters stay slow");
      master_act_i = 8'b0001_0101; run(40);
      chk("R7", slow_o, 0, "three masters force fast");
      master_act_i = 8'h0F; jam_en_i = 0; run(160);
      chk("R7", slow_o, 1, "jam disabled ignored");
      master_act_i = 8'h00;

      // R4: auto slow off forces normal rate even with no activity
      tag = "R4";
      auto_slow_en_i = 0; run(60);
      chk("R4", slow_o, 0, "auto off");

      // R8: wakeup clear, repeated, and ignored when disarmed
      tag = "R8";
      div_wr_i = 1; div_data_i = 5; run(1); div_wr_i = 0;
      wake_irq_i = 1; run(1); wake_irq_i = 0;
      run(3);
      chk("R8", base_div_o, 5, "wake ignored when disarmed");
      auto_clr_en_i = 1;
      wake_irq_i = 1; run(1); wake_irq_i = 0;
      run(12);
      chk("R8", base_div_o, 1, "wake clears");
      div_wr_i = 1; div_data_i = 4; run(1); div_wr_i = 0;
      run(10);
      wake_irq_i = 1; run(1); wake_irq_i = 0;
      run(10);
      chk("R8", base_div_o, 1, "second wake clears");

      // R9: write wins over simultaneous wakeup
      tag = "R9";
      div_wr_i = 1; div_data_i = 6; wake_irq_i = 1; run(1);
      div_wr_i = 0; wake_irq_i = 0;
      run(20);
      chk("R9", base_div_o, 6, "write priority");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      wait (cycles > 100000);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule